// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block holds the loads and stores of an out-of-order core in program order and decides, each cycle, which of them may touch memory without breaking memory data flow. Each slot records whether the operation is a load or a store, its word address and a flag that says whether the address is known yet, the store value and a flag that says whether the value is known yet, and whether the operation has been sent to memory and completed. Addresses and store values arrive after allocation, by slot tag, on two independent write ports.

A load may overtake older operations only when no older, uncompleted store could hold the same address. A store may overtake only when no older, uncompleted operation of either kind could hold the same address. A slot whose address is still unknown counts as a possible match. The oldest slot that is allowed goes out on the request port, one per cycle. The memory side reports completion by tag, and completed slots leave from the oldest end only.

Top module: `memord_queue`

## Requirements
- R1: Allocation is accepted when `alloc_valid` is high and `full` is low. The slot tag given is `alloc_tag`, sampled in the same cycle. Successive allocations receive consecutive tags that wrap from DEPTH-1 to 0.
- R2: A load is held back while an older, uncompleted store with an equal known address exists. It is requested in the cycle after the edge that records that store's completion.
- R3: A load is requested ahead of older operations when every older store has a known, different address or has completed. Older loads never hold back a load.
- R4: A store is never requested before both its address and its value have been written. The request carries the written value on `req_data`.
- R5: A store is held back while any older, uncompleted load or store with an equal known address exists.
- R6: An older slot whose address is unknown blocks every younger store, and blocks younger loads only when that older slot is a store.
- R7: `req_valid` is high for at most one slot per cycle. That slot is the oldest one that may proceed. Each slot is requested exactly once. A request shows on the request port in the cycle right after the edge that records the last write it needed.
- R8: `full` is high when DEPTH slots are held. While `full` is high, allocation is ignored and `alloc_tag` does not move. Slots leave only from the oldest end, one cycle after their completion is recorded. A completed younger slot does not free space while the oldest slot is incomplete.
- R9: After reset the queue is empty: `req_valid` is low, `full` is low and `alloc_tag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate a slot for the next operation in program order |
| alloc_store | input | 1 | Operation type: 1 store, 0 load |
| alloc_tag | output | TAG_W | Tag of the slot that the next allocation receives |
| full | output | 1 | All slots held; allocation stalls |
| addr_valid | input | 1 | Write an effective address into a slot |
| addr_tag | input | TAG_W | Slot receiving the address |
| addr_value | input | ADDR_W | Word address |
| wdata_valid | input | 1 | Write a store value into a slot |
| wdata_tag | input | TAG_W | Slot receiving the value |
| wdata_value | input | DATA_W | Store value |
| req_valid | output | 1 | A memory access is presented this cycle |
| req_tag | output | TAG_W | Slot of the presented access |
| req_store | output | 1 | 1 for a store, 0 for a load |
| req_addr | output | ADDR_W | Address of the access |
| req_data | output | DATA_W | Store value (meaningful for stores) |
| cpl_valid | input | 1 | Memory reports an access as finished |
| cpl_tag | input | TAG_W | Slot of the finished access |

## Verification
A request depends only on registered slot state. So it shows in the cycle right after the edge that captured the last address, value or completion it waited for. It stays for exactly that one cycle, because the next edge marks it as sent. The driver changes inputs one nanosecond after a rising edge and pushes the expected request right after the edge that should release it. The monitor compares on the following falling edge, so every result is checked in the one cycle where it is due. Freed space is checked twice: one nanosecond after the completion edge, where `full` must still be high, and one edge later, where it must have dropped.

// File: rtl/memord_pkg.sv
`timescale 1ns/1ps
package memord_pkg;

  // Per-slot status bits; widths of address and data live in the modules.
  typedef struct packed {
    logic live;     // slot holds an operation
    logic is_st;    // 1 store, 0 load
    logic addr_ok;  // effective address written
    logic data_ok;  // store value written
    logic issued;   // presented on the request port
    logic done;     // memory reported completion
  } slot_flags_t;

endpackage

// File: rtl/memord_slots.sv
`timescale 1ns/1ps
module memord_slots #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               alloc_en,
  input  logic [TAG_W-1:0]                   alloc_idx,
  input  logic                               alloc_st,
  input  logic                               addr_we,
  input  logic [TAG_W-1:0]                   addr_idx,
  input  logic [ADDR_W-1:0]                  addr_in,
  input  logic                               data_we,
  input  logic [TAG_W-1:0]                   data_idx,
  input  logic [DATA_W-1:0]                  data_in,
  input  logic                               issue_en,
  input  logic [TAG_W-1:0]                   issue_idx,
  input  logic                               cpl_en,
  input  logic [TAG_W-1:0]                   cpl_idx,
  input  logic                               retire_en,
  input  logic [TAG_W-1:0]                   retire_idx,
  output memord_pkg::slot_flags_t [DEPTH-1:0] flags,
  output logic [DEPTH-1:0][ADDR_W-1:0]       addr_q,
  output logic [DEPTH-1:0][DATA_W-1:0]       data_q
);
  import memord_pkg::*;

  slot_flags_t [DEPTH-1:0] flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (retire_en && retire_idx == TAG_W'(i)) flags_d[i] = '0;
      if (alloc_en && alloc_idx == TAG_W'(i)) begin
        flags_d[i]       = '0;
        flags_d[i].live  = 1'b1;
        flags_d[i].is_st = alloc_st;
      end
      if (addr_we  && addr_idx  == TAG_W'(i)) flags_d[i].addr_ok = 1'b1;
      if (data_we  && data_idx  == TAG_W'(i)) flags_d[i].data_ok = 1'b1;
      if (issue_en && issue_idx == TAG_W'(i)) flags_d[i].issued  = 1'b1;
      if (cpl_en   && cpl_idx   == TAG_W'(i)) flags_d[i].done    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // Payload storage: enabled writes, no reset needed.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_payload
    always_ff @(posedge clk) begin
      if (addr_we && addr_idx == TAG_W'(gi)) addr_q[gi] <= addr_in;
      if (data_we && data_idx == TAG_W'(gi)) data_q[gi] <= data_in;
    end
  end

  assign flags = flags_q;

endmodule

// File: rtl/memord_hazard.sv
`timescale 1ns/1ps
module memord_hazard #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  memord_pkg::slot_flags_t [DEPTH-1:0] flags,
  input  logic [DEPTH-1:0][ADDR_W-1:0]       addr_q,
  input  logic [TAG_W-1:0]                   head,
  output logic [DEPTH-1:0]                   elig
);

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic [TAG_W-1:0] age_self;
    logic             blocked;

    assign age_self = TAG_W'(gi) - head;

    // Scan every other slot; an older, unfinished one with an unknown or
    // equal address blocks us if either side is a store.
    always_comb begin
      logic [TAG_W-1:0] age_other;
      logic             older;
      logic             may_alias;
      blocked = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        age_other = TAG_W'(j) - head;
        older     = flags[j].live && (age_other < age_self);
        may_alias = !flags[j].addr_ok || (addr_q[j] == addr_q[gi]);
        if ((j != gi) && older && !flags[j].done && may_alias &&
            (flags[j].is_st || flags[gi].is_st))
          blocked = 1'b1;
      end
    end

    assign elig[gi] = flags[gi].live && flags[gi].addr_ok &&
                      !flags[gi].issued && !flags[gi].done &&
                      (!flags[gi].is_st || flags[gi].data_ok) && !blocked;
  end

endmodule

// File: rtl/memord_pick.sv
`timescale 1ns/1ps
module memord_pick #(
  parameter int DEPTH  = 8,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] elig,
  input  logic [TAG_W-1:0] head,
  output logic             pick_valid,
  output logic [TAG_W-1:0] pick_idx
);

  // Walk from the oldest slot towards the youngest; first hit wins.
  always_comb begin
    logic [TAG_W-1:0] idx;
    pick_valid = 1'b0;
    pick_idx   = head;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + TAG_W'(k);
      if (!pick_valid && elig[idx]) begin
        pick_valid = 1'b1;
        pick_idx   = idx;
      end
    end
  end

endmodule

// File: rtl/memord_queue.sv
`timescale 1ns/1ps
module memord_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_store,
  output logic [TAG_W-1:0]  alloc_tag,
  output logic              full,
  input  logic              addr_valid,
  input  logic [TAG_W-1:0]  addr_tag,
  input  logic [ADDR_W-1:0] addr_value,
  input  logic              wdata_valid,
  input  logic [TAG_W-1:0]  wdata_tag,
  input  logic [DATA_W-1:0] wdata_value,
  output logic              req_valid,
  output logic [TAG_W-1:0]  req_tag,
  output logic              req_store,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag
);
  import memord_pkg::*;

  logic [TAG_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             alloc_go, retire_go;

  slot_flags_t [DEPTH-1:0]      flags;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;
  logic [DEPTH-1:0]             elig;
  logic                         pick_valid;
  logic [TAG_W-1:0]             pick_idx;

  assign full      = (count_q == CNT_W'(DEPTH));
  assign alloc_go  = alloc_valid && !full;
  assign retire_go = flags[head_q].live && flags[head_q].done;

  always_comb begin
    head_d  = head_q;
    tail_d  = tail_q;
    count_d = count_q;
    if (alloc_go)  tail_d = tail_q + 1'b1;
    if (retire_go) head_d = head_q + 1'b1;
    case ({alloc_go, retire_go})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  memord_slots #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) slots_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (alloc_go),
    .alloc_idx  (tail_q),
    .alloc_st   (alloc_store),
    .addr_we    (addr_valid),
    .addr_idx   (addr_tag),
    .addr_in    (addr_value),
    .data_we    (wdata_valid),
    .data_idx   (wdata_tag),
    .data_in    (wdata_value),
    .issue_en   (pick_valid),
    .issue_idx  (pick_idx),
    .cpl_en     (cpl_valid),
    .cpl_idx    (cpl_tag),
    .retire_en  (retire_go),
    .retire_idx (head_q),
    .flags      (flags),
    .addr_q     (addr_q),
    .data_q     (data_q)
  );

  memord_hazard #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) hazard_i (
    .flags  (flags),
    .addr_q (addr_q),
    .head   (head_q),
    .elig   (elig)
  );

  memord_pick #(.DEPTH(DEPTH)) pick_i (
    .elig       (elig),
    .head       (head_q),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx)
  );

  assign alloc_tag = tail_q;
  assign req_valid = pick_valid;
  assign req_tag   = pick_idx;
  assign req_store = flags[pick_idx].is_st;
  assign req_addr  = addr_q[pick_idx];
  assign req_data  = data_q[pick_idx];

endmodule

// File: rtl/memord_queue_chk.sv
`timescale 1ns/1ps
module memord_queue_chk #(
  parameter int DEPTH  = 8,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               alloc_valid,
  input logic                               full,
  input logic [TAG_W-1:0]                   alloc_tag,
  input logic                               req_valid,
  input logic [TAG_W-1:0]                   req_tag,
  input logic                               req_store,
  input memord_pkg::slot_flags_t [DEPTH-1:0] flags,
  input logic [TAG_W-1:0]                   head
);

  assert_full_holds_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && alloc_valid) |=> (alloc_tag == $past(alloc_tag)));

  assert_store_has_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store) |-> (flags[req_tag].data_ok && flags[req_tag].addr_ok));

  assert_req_slot_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (flags[req_tag].live && !flags[req_tag].issued && !flags[req_tag].done));

  assert_no_repeat_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !(req_valid && req_tag == $past(req_tag)));

  assert_head_leaves_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[head].live && flags[head].done) |=> (head == TAG_W'($past(head) + 1'b1)));

endmodule

bind memord_queue memord_queue_chk #(.DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .full        (full),
  .alloc_tag   (alloc_tag),
  .req_valid   (req_valid),
  .req_tag     (req_tag),
  .req_store   (req_store),
  .flags       (flags),
  .head        (head_q)
);

// File: tb/memord_queue_tb_top.sv
`timescale 1ns/1ps
module memord_queue_tb_top;

  localparam int DEPTH = 8;
  localparam int TW    = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          alloc_valid, alloc_store;
  logic [TW-1:0] alloc_tag;
  logic          full;
  logic          addr_valid;
  logic [TW-1:0] addr_tag;
  logic [31:0]   addr_value;
  logic          wdata_valid;
  logic [TW-1:0] wdata_tag;
  logic [31:0]   wdata_value;
  logic          req_valid;
  logic [TW-1:0] req_tag;
  logic          req_store;
  logic [31:0]   req_addr, req_data;
  logic          cpl_valid;
  logic [TW-1:0] cpl_tag;

  always #2.5 clk = ~clk;

  memord_queue dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_store(alloc_store), .alloc_tag(alloc_tag), .full(full),
    .addr_valid(addr_valid), .addr_tag(addr_tag), .addr_value(addr_value),
    .wdata_valid(wdata_valid), .wdata_tag(wdata_tag), .wdata_value(wdata_value),
    .req_valid(req_valid), .req_tag(req_tag), .req_store(req_store),
    .req_addr(req_addr), .req_data(req_data),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag)
  );

  typedef struct {
    int          tag;
    bit          st;
    logic [31:0] a;
    logic [31:0] d;
    string       rq;
  } exp_t;

  exp_t expq[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   tail_exp = 0;
  bit   ended = 0;

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_alloc(bit st);
    chk(alloc_tag == TW'(tail_exp), "R1 alloc tag", 64'(alloc_tag), 64'(tail_exp));
    alloc_valid = 1'b1;
    alloc_store = st;
    tick();
    alloc_valid = 1'b0;
    tail_exp = (tail_exp + 1) % DEPTH;
  endtask

  task automatic wr_addr(int t, logic [31:0] a);
    addr_valid = 1'b1; addr_tag = TW'(t); addr_value = a;
    tick();
    addr_valid = 1'b0;
  endtask

  task automatic wr_data(int t, logic [31:0] d);
    wdata_valid = 1'b1; wdata_tag = TW'(t); wdata_value = d;
    tick();
    wdata_valid = 1'b0;
  endtask

  task automatic complete(int t);
    cpl_valid = 1'b1; cpl_tag = TW'(t);
    tick();
    cpl_valid = 1'b0;
  endtask

  task automatic expect_req(int t, bit st, logic [31:0] a, logic [31:0] d, string rq);
    exp_t e;
    e.tag = t; e.st = st; e.a = a; e.d = d; e.rq = rq;
    expq.push_back(e);
  endtask

  task automatic chk_quiet(string rq);
    @(negedge clk);
    chk(!req_valid, rq, 64'(req_valid), 64'd0);
  endtask

  // Monitor: every request on the port must match the oldest expectation.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && req_valid === 1'b1) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R7 unexpected request", 64'(req_tag), 64'hFFFF);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(req_tag == TW'(e.tag), {e.rq, " tag"}, 64'(req_tag), 64'(e.tag));
        chk(req_store == e.st, {e.rq, " type"}, 64'(req_store), 64'(e.st));
        chk(req_addr == e.a, {e.rq, " addr"}, 64'(req_addr), 64'(e.a));
        if (e.st) chk(req_data == e.d, {e.rq, " data"}, 64'(req_data), 64'(e.d));
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    alloc_valid = 0; alloc_store = 0;
    addr_valid = 0; addr_tag = '0; addr_value = '0;
    wdata_valid = 0; wdata_tag = '0; wdata_value = '0;
    cpl_valid = 0; cpl_tag = '0;
    idle(3);
    rst_n = 1'b1;
    // R9: reset state
    chk(!req_valid, "R9 req_valid", 64'(req_valid), 64'd0);
    chk(!full, "R9 full", 64'(full), 64'd0);
    chk(alloc_tag == '0, "R9 alloc_tag", 64'(alloc_tag), 64'd0);

    // Store 0 then load 1, same address
    do_alloc(1'b1); do_alloc(1'b0);
    wr_addr(1, 32'h100);
    chk_quiet("R6 load behind store with unknown address");
    wr_addr(0, 32'h100);
    chk_quiet("R4 store lacks value");
    wr_data(0, 32'hAA);
    expect_req(0, 1, 32'h100, 32'hAA, "R4");
    idle(1);
    chk_quiet("R2 load waits for same-address store");
    complete(0);
    expect_req(1, 0, 32'h100, 0, "R2");
    idle(1);
    complete(1);
    idle(3);

    // Load bypasses store with different address; same-address load waits
    do_alloc(1'b1); do_alloc(1'b0); do_alloc(1'b0);   // tags 2,3,4
    wr_addr(2, 32'h200);
    wr_addr(4, 32'h200);
    chk_quiet("R2 same-address load blocked");
    wr_addr(3, 32'h300);
    expect_req(3, 0, 32'h300, 0, "R3");
    idle(1);
    chk_quiet("R2 load 4 still blocked");
    wr_data(2, 32'hBB);
    expect_req(2, 1, 32'h200, 32'hBB, "R4");
    idle(1);
    complete(3);
    complete(2);
    expect_req(4, 0, 32'h200, 0, "R2");
    idle(1);
    complete(4);
    idle(3);

    // Store behind load: tags 5 (load), 6 (store)
    do_alloc(1'b0); do_alloc(1'b1);
    wr_addr(6, 32'h400);
    wr_data(6, 32'hCC);
    chk_quiet("R6 store behind load with unknown address");
    wr_addr(5, 32'h400);
    expect_req(5, 0, 32'h400, 0, "R5 load first");
    idle(1);
    chk_quiet("R5 store waits for same-address load");
    complete(5);
    expect_req(6, 1, 32'h400, 32'hCC, "R5");
    idle(1);
    complete(6);
    idle(3);

    // Store behind store: tags 7, 0 (wrap)
    do_alloc(1'b1); do_alloc(1'b1);
    wr_data(7, 32'h11);
    wr_data(0, 32'h22);
    wr_addr(0, 32'h500);
    chk_quiet("R6 store behind store with unknown address");
    wr_addr(7, 32'h500);
    expect_req(7, 1, 32'h500, 32'h11, "R5 older store");
    idle(1);
    chk_quiet("R5 store waits for same-address store");
    complete(7);
    expect_req(0, 1, 32'h500, 32'h22, "R5");
    idle(1);
    complete(0);
    idle(3);

    // Two loads released together: oldest first. Tags 1 (store), 2, 3
    do_alloc(1'b1); do_alloc(1'b0); do_alloc(1'b0);
    wr_addr(3, 32'h900);
    wr_addr(2, 32'h904);
    chk_quiet("R6 loads behind store with unknown address");
    wr_addr(1, 32'h800);
    expect_req(2, 0, 32'h904, 0, "R7 oldest first");
    expect_req(3, 0, 32'h900, 0, "R7 next");
    idle(2);
    wr_data(1, 32'h33);
    expect_req(1, 1, 32'h800, 32'h33, "R4");
    idle(1);
    complete(2); complete(3); complete(1);
    idle(3);

    // Load not held by older load with unknown address. Tags 4, 5
    do_alloc(1'b0); do_alloc(1'b0);
    wr_addr(5, 32'hA00);
    expect_req(5, 0, 32'hA00, 0, "R6 older load unknown");
    idle(1);
    wr_addr(4, 32'hA00);
    expect_req(4, 0, 32'hA00, 0, "R3");
    idle(1);
    complete(5); complete(4);
    idle(3);

    // Fill: tags 6,7,0..5
    for (int i = 0; i < DEPTH; i++) do_alloc(1'b0);
    chk(full, "R8 full after DEPTH", 64'(full), 64'd1);
    alloc_valid = 1'b1; alloc_store = 1'b0;
    tick();
    alloc_valid = 1'b0;
    chk(alloc_tag == TW'(6), "R8 tag frozen when full", 64'(alloc_tag), 64'd6);
    chk(full, "R8 still full", 64'(full), 64'd1);
    wr_addr(7, 32'hB00);
    expect_req(7, 0, 32'hB00, 0, "R8 younger load");
    idle(1);
    complete(7);
    idle(2);
    chk(full, "R8 younger completion frees nothing", 64'(full), 64'd1);
    wr_addr(6, 32'hB04);
    expect_req(6, 0, 32'hB04, 0, "R8 head load");
    idle(1);
    complete(6);
    chk(full, "R8 full on completion edge", 64'(full), 64'd1);
    tick();
    chk(!full, "R8 space one cycle later", 64'(full), 64'd0);
    chk(alloc_tag == TW'(6), "R1 tag after wrap", 64'(alloc_tag), 64'd6);
    idle(3);

    chk(expq.size() == 0, "R7 all expected requests seen", 64'(expq.size()), 64'd0);
    finish_run();
  end

endmodule